// File: doc/BRIEF.md
# Flash program/erase protection controller

This block stands between software and an on-chip flash array and decides whether a program or erase operation may begin. If one is already running, it also decides whether that operation must be cancelled. Software reaches it through a small register port. Behind that port sit a primary control register, a secondary control register and a per-block erase-enable register. The outputs are a program-mode enable, an erase-mode enable, a per-block erase mask, a current-state code and a one-cycle abort pulse for the flash sequencer.

Three independent layers can refuse or cancel an operation:

- **Hardware protection.** A qualified external reset, or any power mode other than full-speed active, clears every register and keeps them cleared.
- **Software enable bit.** Writes that request program or erase are refused unless a software enable bit was set by an earlier write.
- **Per-block erase enables.** Each block has its own erase-enable bit. If the whole register is zero, no block can be erased and erase mode is never entered.

The external reset request is only accepted after it has been seen for a minimum number of consecutive clock edges while the oscillator-stable input is high. Shorter glitches are filtered out.

Top module: `flash_guard`

## Requirements
- R1: After the synchronous reset `rst`, every register reads zero, `status_o` is idle and all other outputs are low.
- R2: The primary control register lives at address 0, with P (program) at bit 0, E (erase) at bit 1 and SWE (software enable) at bit 6. A written P or E takes effect only if SWE was already 1 before the write and the written SWE is also 1. Otherwise the bit is stored as 0 and program or erase mode is not entered.
- R3: A write to address 0 with SWE=0 clears P and E, which leaves program or erase mode in that same cycle.
- R4: A write to address 0 that sets both P and E is ignored as a whole, so SWE, P and E keep their previous values.
- R5: While in erase mode, `erase_mask_o` equals the erase-enable register at address 2 (bit i enables block i). Outside erase mode the mask is zero.
- R6: While the erase-enable register is zero, a set E bit stays stored but erase mode is not entered and the mask stays zero.
- R7: At any clock edge where `pwr_mode_i` is not 0 (active), or the qualified reset is high, the registers at addresses 0, 1 and 2 are cleared and any write on that edge is ignored.
- R8: The qualified reset goes high one edge after `rst_req_i` has been sampled high on MIN_RST_CYC consecutive edges with `osc_ok_i` high on the last of them. It falls as soon as either input goes low. A shorter request has no effect.
- R9: `abort_o` pulses high for exactly one cycle when a protection event occurs while in program or erase mode. It never pulses from idle.
- R10: `status_o` encodes idle=0, program=1 and erase=2, and changes on the same edge as the register update that causes it. P takes precedence over E.
- R11: The read path is registered. `rdata_o` shows, one edge later, the register selected by `addr_i`: address 1 is the 8-bit secondary control register, address 3 and unused bits of address 0 read 0, and a value written on the same edge is not yet visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | External reset request, qualified before use |
| osc_ok_i | input | 1 | Oscillator-stable indication |
| pwr_mode_i | input | 3 | 0 active, 1 sub-active, 2 sub-sleep, 3 watch, 4 standby |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| prog_en_o | output | 1 | Program mode active |
| erase_en_o | output | 1 | Erase mode active |
| erase_mask_o | output | 8 | Blocks enabled for erase |
| abort_o | output | 1 | One-cycle cancel pulse to the sequencer |
| status_o | output | 2 | Current mode code |

## Verification
The assertions watch four properties on every cycle:

- A protection event empties all three registers.
- P and E are never set together, and neither is set without SWE.
- The erase mask never names a block whose enable bit is clear, and erase mode never coexists with an all-zero enable register.
- The abort signal is a lone pulse that follows a non-idle state.

Only the bench scenarios can show the following: the ordering rule that SWE must come from an earlier write, that a combined P+E write leaves the old values untouched, how many edges the reset filter waits, and that short or oscillator-less reset requests are ignored.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int CTL1_ADDR = 0;
  localparam int CTL2_ADDR = 1;
  localparam int EBLK_ADDR = 2;

  localparam int BIT_P   = 0;
  localparam int BIT_E   = 1;
  localparam int BIT_SWE = 6;

  typedef enum logic [2:0] {
    PM_ACTIVE = 3'd0,
    PM_SUBACT = 3'd1,
    PM_SUBSLP = 3'd2,
    PM_WATCH  = 3'd3,
    PM_STBY   = 3'd4
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2
  } fl_state_e;
endpackage

// File: rtl/flg_rst_qual.sv
module flg_rst_qual #(
  parameter int MIN_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic osc_ok_i,
  output logic hw_rst_o
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_CYC);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !req_i) begin
      cnt_q    <= '0;
      hw_rst_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      hw_rst_o <= (cnt_n == CNT_MAX) && osc_ok_i;
    end
  end

  assert_qual_needs_osc_R8: assert property (@(posedge clk) disable iff (rst)
    hw_rst_o |-> $past(osc_ok_i) && $past(req_i));
  assert_qual_drops_R8: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !hw_rst_o);
endmodule

// File: rtl/flg_ctl_regs.sv
module flg_ctl_regs
  import flg_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NBLK = 8,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prot_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            p_n_o,
  output logic            e_n_o,
  output logic [NBLK-1:0] eblk_n_o,
  output logic [NBLK-1:0] eblk_q_o,
  output logic [DW-1:0]   rdata_o
);
  logic            swe_q, p_q, e_q;
  logic            swe_n;
  logic [DW-1:0]   ctl2_q, ctl2_n;
  logic [NBLK-1:0] eblk_q, eblk_n;
  logic [DW-1:0]   ctl1_view;
  logic            both_req;

  always_comb begin
    swe_n    = swe_q;
    p_n_o    = p_q;
    e_n_o    = e_q;
    ctl2_n   = ctl2_q;
    eblk_n   = eblk_q;
    both_req = wdata_i[BIT_P] && wdata_i[BIT_E];
    if (prot_i) begin
      swe_n  = 1'b0;
      p_n_o  = 1'b0;
      e_n_o  = 1'b0;
      ctl2_n = '0;
      eblk_n = '0;
    end else if (wr_en_i) begin
      if (addr_i == AW'(CTL1_ADDR) && !both_req) begin
        swe_n = wdata_i[BIT_SWE];
        p_n_o = wdata_i[BIT_P] && wdata_i[BIT_SWE] && swe_q;
        e_n_o = wdata_i[BIT_E] && wdata_i[BIT_SWE] && swe_q;
      end else if (addr_i == AW'(CTL2_ADDR)) begin
        ctl2_n = wdata_i;
      end else if (addr_i == AW'(EBLK_ADDR)) begin
        eblk_n = wdata_i[NBLK-1:0];
      end
    end
  end

  always_comb begin
    ctl1_view          = '0;
    ctl1_view[BIT_P]   = p_q;
    ctl1_view[BIT_E]   = e_q;
    ctl1_view[BIT_SWE] = swe_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      swe_q   <= 1'b0;
      p_q     <= 1'b0;
      e_q     <= 1'b0;
      ctl2_q  <= '0;
      eblk_q  <= '0;
      rdata_o <= '0;
    end else begin
      swe_q  <= swe_n;
      p_q    <= p_n_o;
      e_q    <= e_n_o;
      ctl2_q <= ctl2_n;
      eblk_q <= eblk_n;
      case (addr_i)
        AW'(CTL1_ADDR): rdata_o <= ctl1_view;
        AW'(CTL2_ADDR): rdata_o <= ctl2_q;
        AW'(EBLK_ADDR): rdata_o <= DW'(eblk_q);
        default:        rdata_o <= '0;
      endcase
    end
  end

  assign eblk_n_o = eblk_n;
  assign eblk_q_o = eblk_q;

  assert_prot_clears_R7: assert property (@(posedge clk) disable iff (rst)
    prot_i |=> (!swe_q && !p_q && !e_q && ctl2_q == '0 && eblk_q == '0));
  assert_no_op_without_swe_R2: assert property (@(posedge clk) disable iff (rst)
    !swe_q |-> (!p_q && !e_q));
  assert_p_e_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(p_q && e_q));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flg_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NBLK        = 8,
  parameter int AW          = 2,
  parameter int MIN_RST_CYC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rst_req_i,
  input  logic            osc_ok_i,
  input  logic [2:0]      pwr_mode_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            prog_en_o,
  output logic            erase_en_o,
  output logic [NBLK-1:0] erase_mask_o,
  output logic            abort_o,
  output logic [1:0]      status_o
);
  logic            hw_rst;
  logic            prot;
  logic            p_n, e_n;
  logic [NBLK-1:0] eblk_n, eblk_q;
  fl_state_e       state_n;
  fl_state_e       state_q;

  flg_rst_qual #(.MIN_CYC(MIN_RST_CYC)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .req_i    (rst_req_i),
    .osc_ok_i (osc_ok_i),
    .hw_rst_o (hw_rst)
  );

  assign prot = hw_rst || (pwr_mode_i != PM_ACTIVE);

  flg_ctl_regs #(.DW(DW), .NBLK(NBLK), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .prot_i   (prot),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .p_n_o    (p_n),
    .e_n_o    (e_n),
    .eblk_n_o (eblk_n),
    .eblk_q_o (eblk_q),
    .rdata_o  (rdata_o)
  );

  always_comb begin
    if (p_n)                       state_n = ST_PROG;
    else if (e_n && eblk_n != '0)  state_n = ST_ERASE;
    else                           state_n = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      prog_en_o  <= 1'b0;
      erase_en_o <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      state_q    <= state_n;
      prog_en_o  <= (state_n == ST_PROG);
      erase_en_o <= (state_n == ST_ERASE);
      abort_o    <= prot && (state_q != ST_IDLE);
    end
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) erase_mask_o[b] <= 1'b0;
      else     erase_mask_o[b] <= (state_n == ST_ERASE) && eblk_n[b];
    end
  end

  assign status_o = state_q;

  assert_mask_subset_R5: assert property (@(posedge clk) disable iff (rst)
    (erase_mask_o & ~eblk_q) == '0);
  assert_erase_needs_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERASE) |-> (eblk_q != '0));
  assert_abort_single_R9: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o);
  assert_abort_from_busy_R9: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> ($past(state_q) != ST_IDLE));
  assert_state_legal_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_en_o, erase_en_o}) && (status_o != 2'd3));
endmodule

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb_top;
  localparam int MINC = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_req = 1'b0;
  logic       osc_ok = 1'b1;
  logic [2:0] pwr = 3'd0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       prog_en, erase_en, abort_s;
  logic [7:0] mask;
  logic [1:0] status;

  int total = 0;
  int bad = 0;

  // reference state
  logic       m_swe, m_p, m_e, m_hw, m_abort;
  logic [7:0] m_c2, m_ebr, m_rd;
  logic [1:0] m_st;
  int         m_cnt;

  always #2.5 clk = ~clk;

  flash_guard #(.MIN_RST_CYC(MINC)) dut_i (
    .clk(clk), .rst(rst), .rst_req_i(rst_req), .osc_ok_i(osc_ok),
    .pwr_mode_i(pwr), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .prog_en_o(prog_en), .erase_en_o(erase_en),
    .erase_mask_o(mask), .abort_o(abort_s), .status_o(status)
  );

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] st_of(input logic p, input logic e, input logic [7:0] ebr);
    if (p) return 2'd1;
    if (e && ebr != 8'd0) return 2'd2;
    return 2'd0;
  endfunction

  task automatic step();
    logic       prot;
    logic [7:0] rd_n;
    @(posedge clk);
    if (rst) begin
      {m_swe, m_p, m_e, m_hw, m_abort} = '0;
      m_c2 = 0; m_ebr = 0; m_rd = 0; m_st = 0; m_cnt = 0;
    end else begin
      prot = (pwr != 3'd0) || m_hw;
      case (addr)
        2'd0: rd_n = {1'b0, m_swe, 4'b0, m_e, m_p};
        2'd1: rd_n = m_c2;
        2'd2: rd_n = m_ebr;
        default: rd_n = 8'd0;
      endcase
      m_abort = prot && (m_st != 2'd0);
      if (!rst_req) begin m_cnt = 0; m_hw = 0; end
      else begin
        if (m_cnt < MINC) m_cnt++;
        m_hw = (m_cnt == MINC) && osc_ok;
      end
      if (prot) begin
        m_swe = 0; m_p = 0; m_e = 0; m_c2 = 0; m_ebr = 0;
      end else if (wr) begin
        if (addr == 2'd0 && !(wdata[0] && wdata[1])) begin
          m_p = wdata[0] && wdata[6] && m_swe;
          m_e = wdata[1] && wdata[6] && m_swe;
          m_swe = wdata[6];
        end else if (addr == 2'd1) m_c2 = wdata;
        else if (addr == 2'd2) m_ebr = wdata;
      end
      m_st = st_of(m_p, m_e, m_ebr);
      m_rd = rd_n;
    end
    #1;
    check(status == m_st, "R10 status", {6'd0, status}, {6'd0, m_st});
    check(prog_en == (m_st == 2'd1) && erase_en == (m_st == 2'd2), "R2 mode enables",
          {6'd0, prog_en, erase_en}, {6'd0, m_st == 2'd1, m_st == 2'd2});
    check(mask == ((m_st == 2'd2) ? m_ebr : 8'd0), "R5 mask", mask, (m_st == 2'd2) ? m_ebr : 8'd0);
    check(abort_s == m_abort, "R9 abort", {7'd0, abort_s}, {7'd0, m_abort});
    check(rdata == m_rd, "R11 rdata", rdata, m_rd);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] v);
    wr = 1'b0; addr = a;
    step();
    v = rdata;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    #1;
    step(); step();
    rst = 1'b0;
    step();
    // R1 reset state
    check(status == 0 && !prog_en && !erase_en && mask == 0 && !abort_s && rdata == 0,
          "R1 reset outputs", {status, 6'd0}, 8'd0);
    rreg(2'd0, v); check(v == 8'h00, "R1 ctl1 after reset", v, 8'h00);

    // R2 P without prior SWE
    wreg(2'd0, 8'h41);
    check(status == 2'd0, "R2 P with fresh SWE stays idle", {6'd0, status}, 8'd0);
    rreg(2'd0, v); check(v == 8'h40, "R2 ctl1 keeps SWE only", v, 8'h40);
    wreg(2'd0, 8'h41);
    check(status == 2'd1 && prog_en, "R2 P after SWE enters program", {6'd0, status}, 8'd1);

    // R3 clearing SWE leaves program mode
    wreg(2'd0, 8'h01);
    check(status == 2'd0 && !prog_en, "R3 SWE clear exits program", {6'd0, status}, 8'd0);
    rreg(2'd0, v); check(v == 8'h00, "R3 P forced zero", v, 8'h00);

    // R4 both P and E ignored
    wreg(2'd0, 8'h40);
    wreg(2'd0, 8'h43);
    rreg(2'd0, v); check(v == 8'h40, "R4 combined write ignored", v, 8'h40);
    wreg(2'd0, 8'h41);
    wreg(2'd0, 8'h03);
    check(status == 2'd1, "R4 combined write keeps program", {6'd0, status}, 8'd1);

    // R6 erase with empty block register
    wreg(2'd0, 8'h40);
    wreg(2'd0, 8'h42);
    check(status == 2'd0 && !erase_en && mask == 0, "R6 empty blocks no erase", {6'd0, status}, 8'd0);
    rreg(2'd0, v); check(v == 8'h42, "R6 E stays stored", v, 8'h42);

    // R5 mask follows block register
    wreg(2'd2, 8'hA5);
    check(status == 2'd2 && mask == 8'hA5, "R5 erase mask", mask, 8'hA5);
    wreg(2'd2, 8'h00);
    check(status == 2'd0 && mask == 8'h00, "R6 block register cleared ends erase", mask, 8'h00);
    wreg(2'd2, 8'h18);
    wreg(2'd1, 8'h5C);

    // R7 + R9 watch mode event while erasing
    pwr = 3'd3;
    wreg(2'd2, 8'hFF);
    check(abort_s == 1'b1 && status == 2'd0, "R9 abort on watch entry", {7'd0, abort_s}, 8'd1);
    step();
    check(abort_s == 1'b0, "R9 abort is one cycle", {7'd0, abort_s}, 8'd0);
    wreg(2'd0, 8'h40);
    pwr = 3'd0;
    rreg(2'd0, v); check(v == 8'h00, "R7 write blocked in low power", v, 8'h00);
    rreg(2'd1, v); check(v == 8'h00, "R7 ctl2 cleared", v, 8'h00);
    rreg(2'd2, v); check(v == 8'h00, "R7 block register cleared", v, 8'h00);
    pwr = 3'd4; step(); pwr = 3'd0;
    check(abort_s == 1'b0, "R9 no abort from idle", {7'd0, abort_s}, 8'd0);

    // R8 short request filtered
    wreg(2'd0, 8'h40); wreg(2'd0, 8'h41);
    rst_req = 1'b1;
    for (int i = 0; i < MINC - 1; i++) step();
    rst_req = 1'b0; step();
    check(status == 2'd1, "R8 short reset ignored", {6'd0, status}, 8'd1);
    // R8 no oscillator, no reset
    osc_ok = 1'b0; rst_req = 1'b1;
    for (int i = 0; i < MINC + 4; i++) step();
    check(status == 2'd1, "R8 reset needs osc ok", {6'd0, status}, 8'd1);
    rst_req = 1'b0; step(); osc_ok = 1'b1;
    // R8 full qualified request
    rst_req = 1'b1;
    for (int i = 0; i < MINC; i++) step();
    check(status == 2'd1, "R8 not yet effective", {6'd0, status}, 8'd1);
    step();
    check(status == 2'd0 && abort_s, "R8 qualified reset aborts", {6'd0, status}, 8'd0);
    rst_req = 1'b0; step();

    // random phase
    void'($urandom(32'h1F2E3D4C));
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom();
      pwr   = (r[3:0] == 4'd0) ? 3'(1 + (r[6:4] % 4)) : 3'd0;
      wr    = r[7] | r[8];
      addr  = r[10:9];
      case (r[13:11])
        3'd0: wdata = 8'h40;
        3'd1: wdata = 8'h41;
        3'd2: wdata = 8'h42;
        3'd3: wdata = 8'h43;
        default: wdata = r[21:14];
      endcase
      osc_ok  = 1'b1;
      rst_req = (r[31:24] == 8'd0);
      step();
    end
    wr = 1'b0; rst_req = 1'b0; pwr = 3'd0;
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule